// File: doc/BRIEF.md
# Iterative Radix-4 Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor and returns the quotient and the remainder. It keeps one trial datapath and runs it in a loop. Each pass settles one base-4 digit of the quotient, which is two bits. The dividend width and the divisor width are set at compile time. The quotient is as wide as the dividend. The remainder port is also dividend-wide, because a remainder can never be larger than the dividend.

On each pass the block forms a window from the running remainder and the next two dividend bits, starting with the most significant pair. It subtracts the divisor, twice the divisor and three times the divisor from that window, all three in parallel. Three times the divisor is built as the divisor plus the divisor shifted left by one bit. The largest multiple whose difference is non-negative gives the digit, and that difference becomes the new running remainder. If no difference is non-negative, the digit is 0 and the window passes on unchanged. The window is the divisor width plus two bits, so the three-times multiple always fits.

The control pins are plain and there is no valid/ready handshake. A start pulse is accepted only while busy is low, and a start that arrives while busy is high is dropped. There is no back-pressure on the result. A one-cycle done pulse marks new values on the result ports, and those values stay put until the next done. A caller that needs the result later simply reads the held outputs.

Top module: `r4div`

## Requirements
- R1: A start accepted at a clock edge sets busy at that edge. Done pulses, and busy falls, exactly NSTEP+1 edges later, counting the accepting edge as edge 0. NSTEP = ceil(DVD_W/2), which is one iteration per quotient bit pair.
- R2: For a non-zero divisor, the quotient equals floor(dividend/divisor) and the remainder equals dividend mod divisor, zero-extended to DVD_W bits.
- R3: Each iteration tests the window against 1x, 2x and 3x the divisor at the same time and takes the largest multiple that does not go negative (digit 0 to 3). The running remainder therefore stays below the divisor, and its top two bits stay zero.
- R4: Iterations run from the most significant dividend bit pair down to bits 1:0. Each new digit is shifted into the quotient at the low end.
- R5: An odd DVD_W is zero-extended by one bit at the top, so the result is still exact, for example with DVD_W=7 and NSTEP=4.
- R6: A divisor of zero gives a quotient of all ones and a remainder equal to the dividend. Done still arrives with the R1 latency.
- R7: A start pulse while busy is high is ignored. The operation in flight finishes with its own result, and no extra done follows.
- R8: Done lasts one cycle. The quotient and remainder ports change only in the cycle in which done is high.
- R9: While reset is asserted (rst_n low), busy, done, quotient and remainder are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a division when busy is low |
| dividend_i | input | DVD_W | Dividend, captured on an accepted start |
| divisor_i | input | DVS_W | Divisor, captured on an accepted start |
| busy_o | output | 1 | High while iterations are running |
| done_o | output | 1 | One-cycle pulse when a result is loaded |
| quotient_o | output | DVD_W | Quotient, held until the next done |
| remainder_o | output | DVD_W | Remainder, held until the next done |

## Verification
A dividend of all ones over a divisor of one forces digit 3 on every pass. A design that built 3x wrongly, or that preferred a smaller multiple, would return a wrong quotient there. Divisor zero with non-zero and zero dividends checks the R6 result. A design without the special case would let the running remainder overflow and return garbage. A small instance with an odd dividend width is run over every operand pair, which exposes a missing or misplaced top extension bit. A start pulse during a busy run and a check that the outputs stay steady between done pulses catch a design that re-captures operands or lets its working registers leak onto the ports.

// File: rtl/r4div_pkg.sv
package r4div_pkg;

  typedef logic [1:0] qdigit_t;

  // Largest passing multiple wins: bit 2 = 3x, bit 1 = 2x, bit 0 = 1x.
  function automatic qdigit_t pick_digit(input logic [2:0] fit);
    if (fit[2])      return 2'd3;
    else if (fit[1]) return 2'd2;
    else if (fit[0]) return 2'd1;
    else             return 2'd0;
  endfunction

endpackage

// File: rtl/r4div_mult.sv
module r4div_mult #(
  parameter int DVS_W = 8,
  localparam int WIN_W = DVS_W + 2
) (
  input  logic [DVS_W-1:0]          dvs,
  output logic [2:0][WIN_W-1:0]     mult
);
  logic [WIN_W-1:0] one_x;
  logic [WIN_W-1:0] two_x;

  assign one_x = WIN_W'(dvs);
  assign two_x = WIN_W'({dvs, 1'b0});

  assign mult[0] = one_x;
  assign mult[1] = two_x;
  assign mult[2] = one_x + two_x;
endmodule

// File: rtl/r4div_trial.sv
module r4div_trial #(
  parameter int DVS_W = 8,
  localparam int WIN_W = DVS_W + 2,
  localparam int TRL_W = WIN_W + 1
) (
  input  logic [WIN_W-1:0]          win,
  input  logic [2:0][WIN_W-1:0]     mult,
  output logic [2:0]                fit,
  output logic [2:0][WIN_W-1:0]     diff
);
  for (genvar k = 0; k < 3; k++) begin : g_sub
    logic [TRL_W-1:0] d_full;
    assign d_full  = {1'b0, win} - {1'b0, mult[k]};
    assign fit[k]  = ~d_full[TRL_W-1];
    assign diff[k] = d_full[WIN_W-1:0];
  end
endmodule

// File: rtl/r4div_sel.sv
module r4div_sel
  import r4div_pkg::*;
#(
  parameter int DVS_W = 8,
  localparam int WIN_W = DVS_W + 2
) (
  input  logic [WIN_W-1:0]          win,
  input  logic [2:0]                fit,
  input  logic [2:0][WIN_W-1:0]     diff,
  output qdigit_t                   digit,
  output logic [WIN_W-1:0]          nrem
);
  always_comb begin
    digit = pick_digit(fit);
    unique case (digit)
      2'd3:    nrem = diff[2];
      2'd2:    nrem = diff[1];
      2'd1:    nrem = diff[0];
      default: nrem = win;
    endcase
  end
endmodule

// File: rtl/r4div.sv
module r4div
  import r4div_pkg::*;
#(
  parameter int DVD_W = 16,
  parameter int DVS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] quotient_o,
  output logic [DVD_W-1:0] remainder_o
);
  localparam int EXT_W = DVD_W + (DVD_W % 2);
  localparam int NSTEP = EXT_W / 2;
  localparam int CNT_W = $clog2(NSTEP + 1);
  localparam int WIN_W = DVS_W + 2;

  logic             busy_q, done_q, dz_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] dvd_sh_q, quo_sh_q;
  logic [DVS_W-1:0] dvs_q;
  logic [WIN_W-1:0] prem_q;
  logic [DVD_W-1:0] quotient_q, remainder_q;

  logic [WIN_W-1:0]      win;
  logic [2:0][WIN_W-1:0] mult;
  logic [2:0]            fit;
  logic [2:0][WIN_W-1:0] diff;
  qdigit_t               digit;
  logic [WIN_W-1:0]      nrem;
  logic [1:0]            top_pair;
  logic [EXT_W-1:0]      dvd_nxt, quo_nxt;
  logic                  last_step;

  assign top_pair = dvd_sh_q[EXT_W-1 -: 2];
  assign win      = WIN_W'({prem_q, top_pair});

  r4div_mult #(.DVS_W(DVS_W)) u_mult (.dvs(dvs_q), .mult(mult));

  r4div_trial #(.DVS_W(DVS_W)) u_trial (
    .win(win), .mult(mult), .fit(fit), .diff(diff)
  );

  r4div_sel #(.DVS_W(DVS_W)) u_sel (
    .win(win), .fit(fit), .diff(diff), .digit(digit), .nrem(nrem)
  );

  // Zero divisor: the dividend rotates back into place over NSTEP passes.
  assign dvd_nxt   = (dvd_sh_q << 2) | (dz_q ? EXT_W'(top_pair) : '0);
  assign quo_nxt   = (quo_sh_q << 2) | EXT_W'(dz_q ? 2'b11 : digit);
  assign last_step = (cnt_q == CNT_W'(NSTEP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      dz_q        <= 1'b0;
      cnt_q       <= '0;
      dvd_sh_q    <= '0;
      quo_sh_q    <= '0;
      dvs_q       <= '0;
      prem_q      <= '0;
      quotient_q  <= '0;
      remainder_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q   <= 1'b1;
          cnt_q    <= '0;
          dvd_sh_q <= EXT_W'(dividend_i);
          dvs_q    <= divisor_i;
          dz_q     <= (divisor_i == '0);
          prem_q   <= '0;
          quo_sh_q <= '0;
        end
      end else begin
        dvd_sh_q <= dvd_nxt;
        quo_sh_q <= quo_nxt;
        prem_q   <= dz_q ? prem_q : nrem;
        cnt_q    <= cnt_q + CNT_W'(1);
        if (last_step) begin
          busy_q      <= 1'b0;
          done_q      <= 1'b1;
          quotient_q  <= DVD_W'(quo_nxt);
          remainder_q <= dz_q ? DVD_W'(dvd_nxt) : DVD_W'(nrem);
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign quotient_o  = quotient_q;
  assign remainder_o = remainder_q;
endmodule

// File: rtl/r4div_chk.sv
module r4div_chk #(
  parameter int DVD_W = 16,
  parameter int DVS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [DVD_W-1:0] quotient_o,
  input logic [DVD_W-1:0] remainder_o,
  input logic [DVS_W-1:0] dvs_q,
  input logic [DVS_W+1:0] prem_q
);
  localparam int EXT_W = DVD_W + (DVD_W % 2);
  localparam int NSTEP = EXT_W / 2;
  localparam int CW    = (DVD_W > DVS_W + 2) ? DVD_W : DVS_W + 2;

  int unsigned run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= 0;
    else if (busy_o) run_cnt <= run_cnt + 1;
    else             run_cnt <= 0;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_cnt == NSTEP) && !busy_o);

  p_rem_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && dvs_q != '0) |-> (CW'(remainder_o) < CW'(dvs_q)));

  p_prem_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && dvs_q != '0) |-> (CW'(prem_q) < CW'(dvs_q)));

  p_dz_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && dvs_q == '0) |-> (&quotient_o));

  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(dvs_q));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o)));
endmodule

bind r4div r4div_chk #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .quotient_o(quotient_o), .remainder_o(remainder_o),
  .dvs_q(dvs_q), .prem_q(prem_q)
);

// File: tb/r4div_tb.sv
module r4div_tb;
  localparam int DW = 16, SW = 8, NSTEP = 8;
  localparam int ODW = 7, OSW = 3, ONSTEP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start = 1'b0;
  logic [DW-1:0] dvd = '0;
  logic [SW-1:0] dvs = '0;
  logic          busy, done;
  logic [DW-1:0] quo, rem;

  logic           o_start = 1'b0;
  logic [ODW-1:0] o_dvd = '0;
  logic [OSW-1:0] o_dvs = '0;
  logic           o_busy, o_done;
  logic [ODW-1:0] o_quo, o_rem;

  r4div #(.DVD_W(DW), .DVS_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dividend_i(dvd),
    .divisor_i(dvs), .busy_o(busy), .done_o(done),
    .quotient_o(quo), .remainder_o(rem)
  );

  r4div #(.DVD_W(ODW), .DVS_W(OSW)) u_dut_odd (
    .clk(clk), .rst_n(rst_n), .start_i(o_start), .dividend_i(o_dvd),
    .divisor_i(o_dvs), .busy_o(o_busy), .done_o(o_done),
    .quotient_o(o_quo), .remainder_o(o_rem)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0] exp_q[$], exp_r[$];
  int            exp_c[$];
  string         exp_tag[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: waits for an idle cycle, pulses start, queues the expectation.
  task automatic issue(input logic [DW-1:0] a, input logic [SW-1:0] b,
                       input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; dvd = a; dvs = b;
    exp_q.push_back(b == 0 ? {DW{1'b1}} : a / DW'(b));
    exp_r.push_back(b == 0 ? a : a % DW'(b));
    exp_c.push_back(cyc + 1 + NSTEP);
    exp_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: compares results on done, checks hold between done pulses.
  logic [DW-1:0] last_q = '0, last_r = '0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected done", 1, 0);
        end else begin
          logic [DW-1:0] eq, er;
          int ec;
          string t;
          eq = exp_q.pop_front(); er = exp_r.pop_front();
          ec = exp_c.pop_front(); t = exp_tag.pop_front();
          check(quo == eq, t, "quotient", quo, eq);
          check(rem == er, t, "remainder", rem, er);
          check(cyc == ec, "R1", "done cycle", cyc, ec);
          check(!busy, "R1", "busy low at done", busy, 0);
        end
      end else begin
        if (quo != last_q || rem != last_r)
          check(1'b0, "R8", "outputs moved without done", quo, last_q);
      end
      last_q = quo; last_r = rem;
    end
  end

  task automatic odd_run(input int a, input int b);
    int k = 0;
    logic [ODW-1:0] eq, er;
    @(negedge clk);
    o_start = 1'b1; o_dvd = ODW'(a); o_dvs = OSW'(b);
    @(negedge clk);
    o_start = 1'b0;
    k = 1;
    while (!o_done && k < 40) begin @(negedge clk); k++; end
    eq = (b == 0) ? {ODW{1'b1}} : ODW'(a / b);
    er = (b == 0) ? ODW'(a) : ODW'(a % b);
    check(o_quo == eq, b == 0 ? "R6" : "R5", "odd quotient", o_quo, eq);
    check(o_rem == er, b == 0 ? "R6" : "R5", "odd remainder", o_rem, er);
    check(k == ONSTEP + 1, "R1", "odd latency", k, ONSTEP + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !done, "R9", "busy/done in reset", {busy, done}, 0);
    check(quo == 0 && rem == 0, "R9", "outputs in reset", quo, 0);
    rst_n = 1'b1;

    issue(16'd0, 8'd1, "R2");
    issue(16'hFFFF, 8'd1, "R3");        // digit 3 on every pass
    issue(16'hFFFF, 8'd255, "R3");
    issue(16'd100, 8'd200, "R2");       // dividend below divisor
    issue(16'hC000, 8'd3, "R4");        // only top pair set
    issue(16'd3, 8'd2, "R4");           // only low pair set
    issue(16'd12345, 8'd0, "R6");
    issue(16'd0, 8'd0, "R6");
    issue(16'd40000, 8'd3, "R2");

    // R7: start during busy must be ignored
    issue(16'd1000, 8'd7, "R7");
    start = 1'b1; dvd = 16'd5; dvs = 8'd1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R7", "still busy after ignored start", busy, 1);

    for (int i = 0; i < 200; i++) begin
      logic [DW-1:0] a;
      logic [SW-1:0] b;
      a = DW'($urandom());
      b = SW'($urandom());
      issue(a, b, "R2");
    end

    begin
      int g = 0;
      while (exp_q.size() != 0 && g < 100) begin @(negedge clk); g++; end
    end
    check(exp_q.size() == 0, "R7", "pending results", exp_q.size(), 0);
    repeat (3) @(negedge clk);

    // R5: odd width, every operand pair
    for (int a = 0; a < 128; a++)
      for (int b = 0; b < 8; b++)
        odd_run(a, b);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog expired: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule